// File: doc/BRIEF.md
# External Interrupt Trigger Controller

This block takes 32 asynchronous interrupt pins and turns them into interrupt requests for a processor. Each pin has its own trigger type, mask bit and pending flag. Pins are grouped into banks of eight. Each bank has a trigger-configuration word, a mask word and a pending word, and software reaches all of them through a simple word-addressed register port.

Every pin first passes through a two-flop synchroniser. In edge modes, the synchronised value is compared with its value one cycle earlier. A detected event sets the pin's pending flag whether or not the pin is masked. The mask only gates the outputs.

Pins 0 to 15 each drive a dedicated request line. Pins 16 to 31 are combined into one shared request line. Software clears a pending flag by writing a 1 to its bit. In the level modes the flag sets again as long as the active level stays on the pin.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset, every trigger field holds code 7 (no trigger), so each configuration word reads 0x77777777. Each mask word reads 0x000000FF (all masked), each pending word reads 0, and all request outputs are low.
- R2: A pin change driven between clock edges reaches its pending flag, and the request output, on the third rising clock edge after the change. Two of those edges are taken by the synchroniser and one by the pending register.
- R3: The edge codes are 2 = falling edge, 3 = rising edge and 4 = both edges. A matching transition of the synchronised pin sets the pending flag once, and a steady pin does not set it again after a clear.
- R4: The level codes are 0 = active low and 1 = active high. While the active level is present the pending flag is set on every cycle, so a clear written while the level persists leaves the flag reading 1. After the level is removed, a clear leaves it at 0.
- R5: Codes 5, 6 and 7 never set the pending flag, whatever the pin does.
- R6: Within a bank, lane L (pin 8*bank+L) uses configuration bits [4L+2:4L]. Bit 4L+3 is not stored and reads 0.
- R7: A mask bit of 1 blocks the pin's request and 0 lets it through. A mask word reads back the stored low 8 bits, with bits 31:8 reading 0. A masked pin still sets its pending flag.
- R8: Writing 1 to a pending bit clears it and writing 0 leaves it unchanged. If a new event arrives in the same cycle as the clear, the flag stays set. Pending bits 31:8 read 0.
- R9: irq_direct[k] for k in 0..15 is high exactly when pin k is pending and unmasked. It follows the register state in the same cycle.
- R10: irq_shared is high exactly when at least one of pins 16..31 is pending and unmasked.
- R11: Byte address bits [5:4] select the register group: 0 = configuration, 1 = mask, 2 = pending. Bits [3:2] select the bank and bits [1:0] are ignored. Group 3 reads 0, and writes to it change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| pins | input | 32 | Asynchronous external interrupt pins |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Byte address of the register word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| irq_direct | output | 16 | Dedicated request lines for pins 0..15 |
| irq_shared | output | 1 | Combined request line for pins 16..31 |

## Verification
The embedded assertions are checked on every cycle. They cover the sticky behaviour of each pending flag, the write-one-to-clear rule with its set-wins priority, the silence of codes 5 to 7, detection of a rising edge, and the zero upper bits of the mask, pending and unused-group reads.

Only the bench scenarios can show the rest: the exact three-edge latency through the synchroniser, the re-set of level-mode flags after a clear, and the independence of masking from pending. The same holds for the mapping of each configuration nibble to its pin and for the split between dedicated and shared request lines. The bench shows these by comparing the outputs against a cycle model driven with random pin activity and register writes.

// File: rtl/eint_pkg.sv
package eint_pkg;

  localparam logic [2:0] TRIG_LVL_LO = 3'd0;
  localparam logic [2:0] TRIG_LVL_HI = 3'd1;
  localparam logic [2:0] TRIG_FALL   = 3'd2;
  localparam logic [2:0] TRIG_RISE   = 3'd3;
  localparam logic [2:0] TRIG_BOTH   = 3'd4;
  localparam logic [2:0] TRIG_NONE   = 3'd7;

  localparam logic [1:0] GRP_CFG  = 2'd0;
  localparam logic [1:0] GRP_MASK = 2'd1;
  localparam logic [1:0] GRP_PEND = 2'd2;

  // Decide whether a lane raises an event this cycle.
  function automatic logic trig_hit(input logic [2:0] mode,
                                    input logic cur, input logic prv);
    logic h;
    case (mode)
      TRIG_LVL_LO: h = ~cur;
      TRIG_LVL_HI: h = cur;
      TRIG_FALL:   h = ~cur & prv;
      TRIG_RISE:   h = cur & ~prv;
      TRIG_BOTH:   h = cur ^ prv;
      default:     h = 1'b0;
    endcase
    return h;
  endfunction

endpackage

// File: rtl/eint_rst_sync.sv
module eint_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) stage_q <= 2'b00;
    else          stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_o = stage_q[1];
endmodule

// File: rtl/eint_sync.sv
module eint_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pins_i,
  output logic [W-1:0] cur_o,
  output logic [W-1:0] prv_o
);
  logic [W-1:0] meta_q, cur_q, prv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      cur_q  <= '0;
      prv_q  <= '0;
    end else begin
      meta_q <= pins_i;
      cur_q  <= meta_q;
      prv_q  <= cur_q;
    end
  end

  assign cur_o = cur_q;
  assign prv_o = prv_q;
endmodule

// File: rtl/eint_bank.sv
module eint_bank
  import eint_pkg::*;
#(
  parameter int LANES = 8,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             mask_we,
  input  logic             pend_we,
  input  logic [DW-1:0]    wdata,
  input  logic [LANES-1:0] cur_i,
  input  logic [LANES-1:0] prv_i,
  output logic [DW-1:0]    cfg_rd,
  output logic [LANES-1:0] mask_o,
  output logic [LANES-1:0] pend_o
);
  localparam int NIB = 4;
  localparam int CFG_BITS = NIB * LANES;

  logic [2:0]       mode_q [LANES];
  logic [2:0]       mode_d [LANES];
  logic [LANES-1:0] mask_q, mask_d;
  logic [LANES-1:0] pend_q, pend_d;
  logic [LANES-1:0] hit;
  logic [LANES-1:0] clr;

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      mode_d[l] = cfg_we ? wdata[NIB*l +: 3] : mode_q[l];
    end
    mask_d = mask_we ? wdata[LANES-1:0] : mask_q;
    clr    = pend_we ? wdata[LANES-1:0] : '0;
    pend_d = (pend_q & ~clr) | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int l = 0; l < LANES; l++) mode_q[l] <= TRIG_NONE;
    end else if (cfg_we) begin
      for (int l = 0; l < LANES; l++) mode_q[l] <= mode_d[l];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '1;
    else if (mask_we) mask_q <= mask_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign hit[l] = trig_hit(mode_q[l], cur_i[l], prv_i[l]);
    assign cfg_rd[NIB*l +: NIB] = {1'b0, mode_q[l]};

    // R8
    pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q[l] && !(pend_we && wdata[l])) |=> pend_q[l]);
    // R8
    pend_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_we && wdata[l] && !hit[l]) |=> !pend_q[l]);
    // R5
    no_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[l] >= 3'd5 && !pend_q[l]) |=> !pend_q[l]);
    // R3
    rise_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[l] == TRIG_RISE && cur_i[l] && !prv_i[l]) |=> pend_q[l]);
  end

  if (DW > CFG_BITS) begin : g_cfg_pad
    assign cfg_rd[DW-1:CFG_BITS] = '0;
  end

  logic unused_wdata;
  assign unused_wdata = ^wdata;

  assign mask_o = mask_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import eint_pkg::*;
#(
  parameter int NUM_PINS   = 32,
  parameter int LANES      = 8,
  parameter int NUM_DIRECT = 16,
  parameter int DW         = 32,
  parameter int ADDR_W     = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_PINS-1:0]   pins,
  input  logic                  reg_we,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [DW-1:0]         reg_wdata,
  output logic [DW-1:0]         reg_rdata,
  output logic [NUM_DIRECT-1:0] irq_direct,
  output logic                  irq_shared
);
  localparam int NUM_BANKS = NUM_PINS / LANES;
  localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam int GRP_LSB   = 2 + BANK_W;

  logic rst_n_int;
  logic [NUM_PINS-1:0] cur, prv;
  logic [NUM_PINS-1:0] pend_all, mask_all, active;
  logic [1:0]          grp;
  logic [BANK_W-1:0]   bank_sel;

  logic [DW-1:0]    cfg_rd_b  [NUM_BANKS];
  logic [LANES-1:0] mask_b    [NUM_BANKS];
  logic [LANES-1:0] pend_b    [NUM_BANKS];

  eint_rst_sync u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_int)
  );

  eint_sync #(.W(NUM_PINS)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .pins_i (pins),
    .cur_o  (cur),
    .prv_o  (prv)
  );

  assign grp      = reg_addr[GRP_LSB +: 2];
  assign bank_sel = reg_addr[2 +: BANK_W];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic sel;
    assign sel = (bank_sel == BANK_W'(b));

    eint_bank #(.LANES(LANES), .DW(DW)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n_int),
      .cfg_we  (reg_we && sel && grp == GRP_CFG),
      .mask_we (reg_we && sel && grp == GRP_MASK),
      .pend_we (reg_we && sel && grp == GRP_PEND),
      .wdata   (reg_wdata),
      .cur_i   (cur[b*LANES +: LANES]),
      .prv_i   (prv[b*LANES +: LANES]),
      .cfg_rd  (cfg_rd_b[b]),
      .mask_o  (mask_b[b]),
      .pend_o  (pend_b[b])
    );

    assign pend_all[b*LANES +: LANES] = pend_b[b];
    assign mask_all[b*LANES +: LANES] = mask_b[b];
  end

  always_comb begin
    case (grp)
      GRP_CFG:  reg_rdata = cfg_rd_b[bank_sel];
      GRP_MASK: reg_rdata = {{(DW-LANES){1'b0}}, mask_b[bank_sel]};
      GRP_PEND: reg_rdata = {{(DW-LANES){1'b0}}, pend_b[bank_sel]};
      default:  reg_rdata = '0;
    endcase
  end

  assign active     = pend_all & ~mask_all;
  assign irq_direct = active[NUM_DIRECT-1:0];
  assign irq_shared = |active[NUM_PINS-1:NUM_DIRECT];

  logic unused_addr;
  assign unused_addr = ^reg_addr[1:0];

  // R7
  mask_hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (grp == GRP_MASK) |-> (reg_rdata[DW-1:LANES] == '0));
  // R8
  pend_hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (grp == GRP_PEND) |-> (reg_rdata[DW-1:LANES] == '0));
  // R11
  void_grp_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (grp == 2'd3) |-> (reg_rdata == '0));
  // R10
  shared_idle_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (pend_all[NUM_PINS-1:NUM_DIRECT] == '0) |-> !irq_shared);
endmodule

// File: tb/tb_ext_irq_ctrl.sv
module tb_ext_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pins = '0;
  logic        reg_we = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [15:0] irq_direct;
  logic        irq_shared;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  ext_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .pins(pins), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_direct(irq_direct), .irq_shared(irq_shared)
  );

  // Cycle model of the requirements
  logic [2:0]  m_cfg [32];
  logic [31:0] m_mask, m_pend, ms1, ms2, mp;

  function automatic logic hit_of(input logic [2:0] m, input logic c, input logic p);
    case (m)
      3'd0: return ~c;
      3'd1: return c;
      3'd2: return ~c & p;
      3'd3: return c & ~p;
      3'd4: return c ^ p;
      default: return 1'b0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) m_cfg[i] = 3'd7;
      m_mask = '1; m_pend = '0; ms1 = '0; ms2 = '0; mp = '0;
    end else begin
      logic [31:0] h, clr;
      int b;
      for (int i = 0; i < 32; i++) h[i] = hit_of(m_cfg[i], ms2[i], mp[i]);
      clr = '0;
      b = int'(reg_addr[3:2]);
      if (reg_we) begin
        case (reg_addr[5:4])
          2'd0: for (int l = 0; l < 8; l++) m_cfg[b*8+l] = reg_wdata[4*l +: 3];
          2'd1: m_mask[b*8 +: 8] = reg_wdata[7:0];
          2'd2: clr[b*8 +: 8] = reg_wdata[7:0];
          default: ;
        endcase
      end
      m_pend = (m_pend & ~clr) | h;
      mp = ms2; ms2 = ms1; ms1 = pins;
    end
  end

  function automatic logic [31:0] exp_rd(input logic [5:0] a);
    int b;
    logic [31:0] r;
    b = int'(a[3:2]);
    r = '0;
    case (a[5:4])
      2'd0: for (int l = 0; l < 8; l++) r[4*l +: 4] = {1'b0, m_cfg[b*8+l]};
      2'd1: r[7:0] = m_mask[b*8 +: 8];
      2'd2: r[7:0] = m_pend[b*8 +: 8];
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic model_chk();
    logic [31:0] act_v;
    string tag;
    act_v = m_pend & ~m_mask;
    chk("R9", {16'h0, irq_direct}, {16'h0, act_v[15:0]});
    chk("R10", {31'h0, irq_shared}, {31'h0, |act_v[31:16]});
    case (reg_addr[5:4])
      2'd0: tag = "R6";
      2'd1: tag = "R7";
      2'd2: tag = "R8";
      default: tag = "R11";
    endcase
    chk(tag, reg_rdata, exp_rd(reg_addr));
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    #1;
    model_chk();
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_we = 1'b0;
  endtask

  task automatic rd(input string req, input logic [5:0] a, input logic [31:0] e);
    reg_addr = a;
    #1;
    chk(req, reg_rdata, e);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=%h exp=%h", 32'h1, 32'h0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) tick();

    // R1 reset state
    rd("R1", 6'h00, 32'h7777_7777);
    rd("R1", 6'h1C, 32'h0000_00FF);
    rd("R1", 6'h24, 32'h0);
    chk("R1", {15'h0, irq_shared, irq_direct}, 32'h0);

    // R2 latency, rising edge on pin 3
    wr(6'h00, 32'h7777_3777);
    wr(6'h10, 32'hFFFF_FFF7);
    pins[3] = 1'b1;
    tick(); chk("R2", {31'h0, irq_direct[3]}, 32'h0);
    tick(); chk("R2", {31'h0, irq_direct[3]}, 32'h0);
    tick(); chk("R2", {31'h0, irq_direct[3]}, 32'h1);

    // R8 clear, R3 no re-set on steady pin, then falling edge
    wr(6'h20, 32'h0000_0008);
    rd("R8", 6'h20, 32'h0);
    tick(); rd("R3", 6'h20, 32'h0);
    wr(6'h20, 32'h0000_0000);
    wr(6'h00, 32'h7777_2777);
    pins[3] = 1'b0;
    repeat (3) tick();
    rd("R3", 6'h20, 32'h0000_0008);
    wr(6'h20, 32'h0000_0000);
    rd("R8", 6'h20, 32'h0000_0008);

    // R4 level high on pin 5
    wr(6'h00, 32'h7717_7777);
    pins[5] = 1'b1;
    repeat (3) tick();
    wr(6'h20, 32'h0000_00FF);
    rd("R4", 6'h20, 32'h0000_0020);
    pins[5] = 1'b0;
    repeat (3) tick();
    wr(6'h20, 32'h0000_0020);
    rd("R4", 6'h20, 32'h0);

    // R5 code 6 ignores activity
    wr(6'h00, 32'h7767_7777);
    for (int i = 0; i < 6; i++) begin
      pins[5] = ~pins[5];
      tick();
    end
    repeat (3) tick();
    rd("R5", 6'h20, 32'h0);

    // R7 masked pin 20 still pends; R10 shared after unmask
    wr(6'h08, 32'h7773_7777);
    pins[20] = 1'b1;
    repeat (3) tick();
    rd("R7", 6'h28, 32'h0000_0010);
    chk("R7", {31'h0, irq_shared}, 32'h0);
    wr(6'h18, 32'hFFFF_FFEF);
    rd("R7", 6'h18, 32'h0000_00EF);
    chk("R10", {31'h0, irq_shared}, 32'h1);

    // R6 bit 3 of each nibble not stored
    wr(6'h0C, 32'hFFFF_FFFF);
    rd("R6", 6'h0C, 32'h7777_7777);
    wr(6'h0C, 32'h7777_7777);

    // R11 group 3
    wr(6'h34, 32'hFFFF_FFFF);
    rd("R11", 6'h30, 32'h0);
    rd("R11", 6'h18, 32'h0000_00EF);

    // Random phase against the model
    for (int n = 0; n < 4000; n++) begin
      pins = pins ^ ($urandom & $urandom & $urandom);
      if (($urandom % 4) == 0) begin
        reg_we = 1'b1;
        reg_addr = 6'($urandom);
        reg_wdata = $urandom;
      end else begin
        reg_we = 1'b0;
        reg_addr = 6'($urandom);
      end
      tick();
    end
    reg_we = 1'b0;

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule